// File: doc/BRIEF.md
# Boundary-Scan Traffic Monitor

This block watches a four-wire boundary-scan test port without driving any of its pins. It samples the test clock, mode select, data-in and data-out lines with the system clock. It rebuilds the sixteen-state test access controller from the mode-select value seen at each rising test-clock edge. It gathers the bits shifted during instruction and data scans and hands them to its consumer as framed reports.

Every rising test-clock edge produces a state record holding the state just entered and the state left. When a shift phase ends by moving into the matching first exit state, the block emits one report. The report holds the data-in stream and the data-out stream, with the earliest-shifted bit in bit 0. It also holds the bit count, a flag that tells instruction scans from data scans, and an overflow flag. Both kinds of output are single-cycle pulses in the system clock domain and have no back-pressure. The test clock must stay at least four system clocks per period.

Top module: `scan_monitor`

## Requirements
- R1: The tracked state changes only on a rising edge of the synchronized test clock. Changes on mode select or data lines, and falling test-clock edges, leave `st_cur_o` unchanged.
- R2: While reset is asserted and after it is released, `st_cur_o` and `st_prev_o` read 1 (run/idle), and both valid pulses are low.
- R3: State codes are 0 reset, 1 run/idle, 2 DR-select, 3 DR-capture, 4 DR-update, 5 DR-pause, 6 DR-shift, 7 DR-exit1, 8 DR-exit2, 9 IR-select, 10 IR-capture, 11 IR-update, 12 IR-pause, 13 IR-shift, 14 IR-exit1, 15 IR-exit2. Transitions follow the standard test access controller graph using the mode-select value sampled at the rising edge.
- R4: Each rising edge gives a one-cycle `st_vld_o`. `st_cur_o` then holds the newly entered state and `st_prev_o` the state before it.
- R5: `st_vld_o` goes high at the third system clock edge after the edge that first samples the test clock high. It is low one cycle earlier.
- R6: When the newly entered state is a shift state (6 or 13), the data-in and data-out values taken at that same edge are appended to the capture. The data-out stream is reported exactly like the data-in stream.
- R7: A report (`rpt_vld_o`) is emitted only when the previous state is a shift state and the new state is its exit1 state (6 to 7, or 13 to 14). It coincides with that state record. Moving from capture straight to exit1 emits no report.
- R8: Report bit i is the i-th bit shifted, counting from 0. Bits at or above the count are zero. `rpt_len_o` equals the number of shifted bits.
- R9: `rpt_is_ir_o` is 1 when the report closes at state 14 and 0 when it closes at state 7.
- R10: With more than MAXBITS bits, only the first MAXBITS are stored, `rpt_len_o` still counts all bits, and `rpt_ovf_o` is 1. With exactly MAXBITS bits, `rpt_ovf_o` is 0.
- R11: The capture is cleared after each report. A shift phase resumed through pause and exit2 starts a new report from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed data into the target |
| tdo_i | input | 1 | Observed data out of the target |
| st_vld_o | output | 1 | One-cycle pulse per rising test-clock edge |
| st_cur_o | output | 4 | Current tracked state code |
| st_prev_o | output | 4 | State before the last transition |
| rpt_vld_o | output | 1 | One-cycle pulse when a scan report is ready |
| rpt_is_ir_o | output | 1 | Report closes an instruction scan |
| rpt_tdi_o | output | MAXBITS | Captured data-in bits, first shifted in bit 0 |
| rpt_tdo_o | output | MAXBITS | Captured data-out bits, first shifted in bit 0 |
| rpt_len_o | output | CNT_W | Number of bits shifted in the scan |
| rpt_ovf_o | output | 1 | More bits were shifted than could be stored |

## Verification
Every result is due three system clock edges after the edge that first samples the new pin values. Two of those edges are the synchronizer. The third registers the decoded event into the state record and the report. The reference model keeps a three-deep history of sampled pins, so it acts on the same delayed sample. Outputs are compared on the falling edge after the DUT's register update. A directed probe confirms that the state pulse is still low one cycle before it is due, and high in the cycle it is due.

// File: rtl/scanmon_pkg.sv
package scanmon_pkg;

  // Tracked controller state; the numeric codes are visible at the ports.
  typedef enum logic [3:0] {
    S_RESET  = 4'd0,
    S_IDLE   = 4'd1,
    S_DSEL   = 4'd2,
    S_DCAP   = 4'd3,
    S_DUPD   = 4'd4,
    S_DPAUSE = 4'd5,
    S_DSHIFT = 4'd6,
    S_DEXIT1 = 4'd7,
    S_DEXIT2 = 4'd8,
    S_ISEL   = 4'd9,
    S_ICAP   = 4'd10,
    S_IUPD   = 4'd11,
    S_IPAUSE = 4'd12,
    S_ISHIFT = 4'd13,
    S_IEXIT1 = 4'd14,
    S_IEXIT2 = 4'd15
  } tap_st_e;

  function automatic logic is_shift(tap_st_e s);
    return (s == S_DSHIFT) || (s == S_ISHIFT);
  endfunction

  // True when s is the exit1 state reached from the shift state sh.
  function automatic logic closes_shift(tap_st_e sh, tap_st_e s);
    return ((sh == S_DSHIFT) && (s == S_DEXIT1)) ||
           ((sh == S_ISHIFT) && (s == S_IEXIT1));
  endfunction

endpackage

// File: rtl/scanmon_sync.sv
module scanmon_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    logic s1_q;
    logic s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end

endmodule

// File: rtl/scanmon_tap.sv
module scanmon_tap
  import scanmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv_i,
  input  logic    tms_i,
  output tap_st_e cur_o,
  output tap_st_e nxt_o,
  output tap_st_e prev_o
);

  tap_st_e cur_q, cur_d;
  tap_st_e prev_q, prev_d;
  tap_st_e step;

  always_comb begin
    step = cur_q;
    case (cur_q)
      S_RESET:  step = tms_i ? S_RESET  : S_IDLE;
      S_IDLE:   step = tms_i ? S_DSEL   : S_IDLE;
      S_DSEL:   step = tms_i ? S_ISEL   : S_DCAP;
      S_DCAP:   step = tms_i ? S_DEXIT1 : S_DSHIFT;
      S_DSHIFT: step = tms_i ? S_DEXIT1 : S_DSHIFT;
      S_DEXIT1: step = tms_i ? S_DUPD   : S_DPAUSE;
      S_DPAUSE: step = tms_i ? S_DEXIT2 : S_DPAUSE;
      S_DEXIT2: step = tms_i ? S_DUPD   : S_DSHIFT;
      S_DUPD:   step = tms_i ? S_DSEL   : S_IDLE;
      S_ISEL:   step = tms_i ? S_RESET  : S_ICAP;
      S_ICAP:   step = tms_i ? S_IEXIT1 : S_ISHIFT;
      S_ISHIFT: step = tms_i ? S_IEXIT1 : S_ISHIFT;
      S_IEXIT1: step = tms_i ? S_IUPD   : S_IPAUSE;
      S_IPAUSE: step = tms_i ? S_IEXIT2 : S_IPAUSE;
      S_IEXIT2: step = tms_i ? S_IUPD   : S_ISHIFT;
      S_IUPD:   step = tms_i ? S_DSEL   : S_IDLE;
      default:  step = S_IDLE;
    endcase
  end

  always_comb begin
    cur_d  = cur_q;
    prev_d = prev_q;
    if (adv_i) begin
      cur_d  = step;
      prev_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= S_IDLE;
      prev_q <= S_IDLE;
    end else begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  assign cur_o  = cur_q;
  assign nxt_o  = step;
  assign prev_o = prev_q;

endmodule

// File: rtl/scanmon_capture.sv
module scanmon_capture
  import scanmon_pkg::*;
#(
  parameter int MAXBITS = 64,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  tap_st_e            old_st_i,
  input  tap_st_e            new_st_i,
  input  logic               tdi_i,
  input  logic               tdo_i,
  output logic               rpt_vld_o,
  output logic               rpt_ir_o,
  output logic [MAXBITS-1:0] rpt_tdi_o,
  output logic [MAXBITS-1:0] rpt_tdo_o,
  output logic [CNT_W-1:0]   rpt_len_o,
  output logic               rpt_ovf_o
);

  localparam logic [CNT_W-1:0] CAP_C   = CNT_W'(MAXBITS);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic               append, close;
  logic [MAXBITS-1:0] tdi_buf_q, tdi_buf_d, tdo_buf_q, tdo_buf_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ovf_q, ovf_d;

  logic               rv_q, rir_q, rovf_q;
  logic [MAXBITS-1:0] rtdi_q, rtdo_q;
  logic [CNT_W-1:0]   rlen_q;

  assign append = adv_i && is_shift(new_st_i);
  assign close  = adv_i && closes_shift(old_st_i, new_st_i);

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (close) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (append) begin
      if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
      if (cnt_q >= CAP_C)   ovf_d = 1'b1;
    end
  end

  // Indexed write: the bit lands at the current count, so the first one sits in bit 0.
  always_comb begin
    tdi_buf_d = tdi_buf_q;
    tdo_buf_d = tdo_buf_q;
    if (close) begin
      tdi_buf_d = '0;
      tdo_buf_d = '0;
    end else if (append) begin
      for (int i = 0; i < MAXBITS; i++) begin
        if (cnt_q == CNT_W'(i)) begin
          tdi_buf_d[i] = tdi_i;
          tdo_buf_d[i] = tdo_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdi_buf_q <= '0;
      tdo_buf_q <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      tdi_buf_q <= tdi_buf_d;
      tdo_buf_q <= tdo_buf_d;
      cnt_q     <= cnt_d;
      ovf_q     <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      rir_q  <= 1'b0;
      rovf_q <= 1'b0;
      rtdi_q <= '0;
      rtdo_q <= '0;
      rlen_q <= '0;
    end else begin
      rv_q <= close;
      if (close) begin
        rir_q  <= (new_st_i == S_IEXIT1);
        rovf_q <= ovf_q;
        rtdi_q <= tdi_buf_q;
        rtdo_q <= tdo_buf_q;
        rlen_q <= cnt_q;
      end
    end
  end

  assign rpt_vld_o = rv_q;
  assign rpt_ir_o  = rir_q;
  assign rpt_tdi_o = rtdi_q;
  assign rpt_tdo_o = rtdo_q;
  assign rpt_len_o = rlen_q;
  assign rpt_ovf_o = rovf_q;

endmodule

// File: rtl/scan_monitor.sv
module scan_monitor
  import scanmon_pkg::*;
#(
  parameter int MAXBITS = 64,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tck_i,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic               tdo_i,
  output logic               st_vld_o,
  output logic [3:0]         st_cur_o,
  output logic [3:0]         st_prev_o,
  output logic               rpt_vld_o,
  output logic               rpt_is_ir_o,
  output logic [MAXBITS-1:0] rpt_tdi_o,
  output logic [MAXBITS-1:0] rpt_tdo_o,
  output logic [CNT_W-1:0]   rpt_len_o,
  output logic               rpt_ovf_o
);

  localparam int PINS = 4;

  logic [PINS-1:0] pins_s;
  logic            tck_s, tms_s, tdi_s, tdo_s;
  logic            tck_q;
  logic            rise;
  logic            stv_q;
  tap_st_e         cur_st, nxt_st, prev_st;

  scanmon_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({tck_i, tms_i, tdi_i, tdo_i}),
    .q_o   (pins_s)
  );

  assign {tck_s, tms_s, tdi_s, tdo_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q <= 1'b0;
      stv_q <= 1'b0;
    end else begin
      tck_q <= tck_s;
      stv_q <= rise;
    end
  end

  assign rise = tck_s && !tck_q;

  scanmon_tap u_tap (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (rise),
    .tms_i  (tms_s),
    .cur_o  (cur_st),
    .nxt_o  (nxt_st),
    .prev_o (prev_st)
  );

  scanmon_capture #(.MAXBITS(MAXBITS), .CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (rise),
    .old_st_i  (cur_st),
    .new_st_i  (nxt_st),
    .tdi_i     (tdi_s),
    .tdo_i     (tdo_s),
    .rpt_vld_o (rpt_vld_o),
    .rpt_ir_o  (rpt_is_ir_o),
    .rpt_tdi_o (rpt_tdi_o),
    .rpt_tdo_o (rpt_tdo_o),
    .rpt_len_o (rpt_len_o),
    .rpt_ovf_o (rpt_ovf_o)
  );

  assign st_vld_o  = stv_q;
  assign st_cur_o  = cur_st;
  assign st_prev_o = prev_st;

endmodule

// File: rtl/scanmon_chk.sv
module scanmon_chk #(
  parameter int MAXBITS = 64,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_vld_o,
  input logic [3:0]         st_cur_o,
  input logic [3:0]         st_prev_o,
  input logic               rpt_vld_o,
  input logic               rpt_is_ir_o,
  input logic [MAXBITS-1:0] rpt_tdi_o,
  input logic [CNT_W-1:0]   rpt_len_o,
  input logic               rpt_ovf_o
);

  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(MAXBITS);

  // R1: the tracked state moves only together with a state record
  a_r1_move_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_cur_o) |-> st_vld_o);

  // R4: the previous-state field holds what was current before the pulse
  a_r4_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld_o |-> (st_prev_o == $past(st_cur_o)));

  // R7: a report only accompanies a shift-to-exit1 state record
  a_r7_report_framing: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld_o |-> (st_vld_o &&
                   ((st_prev_o == 4'd6 && st_cur_o == 4'd7) ||
                    (st_prev_o == 4'd13 && st_cur_o == 4'd14))));

  // R8: a report always carries at least one bit
  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld_o |-> (rpt_len_o != '0));

  // R8: nothing is stored above the bit count when no overflow happened
  a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_vld_o && !rpt_ovf_o) |-> ((rpt_tdi_o >> rpt_len_o) == '0));

  // R9: the scan kind follows the exit1 state entered
  a_r9_kind_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld_o |-> (rpt_is_ir_o == (st_cur_o == 4'd14)));

  // R10: overflow is flagged exactly when the count exceeds storage
  a_r10_ovf_len: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_vld_o |-> (rpt_ovf_o == (rpt_len_o > CAP_C)));

endmodule

bind scan_monitor scanmon_chk #(.MAXBITS(MAXBITS), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_vld_o    (st_vld_o),
  .st_cur_o    (st_cur_o),
  .st_prev_o   (st_prev_o),
  .rpt_vld_o   (rpt_vld_o),
  .rpt_is_ir_o (rpt_is_ir_o),
  .rpt_tdi_o   (rpt_tdi_o),
  .rpt_len_o   (rpt_len_o),
  .rpt_ovf_o   (rpt_ovf_o)
);

// File: tb/scan_monitor_tb_top.sv
module scan_monitor_tb_top;
  localparam int MAXB = 64;
  localparam int CW   = 16;
  typedef logic [MAXB-1:0] vec_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tck, tms, tdi, tdo;
  logic st_vld_o, rpt_vld_o, rpt_is_ir_o, rpt_ovf_o;
  logic [3:0] st_cur_o, st_prev_o;
  logic [MAXB-1:0] rpt_tdi_o, rpt_tdo_o;
  logic [CW-1:0] rpt_len_o;

  scan_monitor #(.MAXBITS(MAXB), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .tdo_i(tdo),
    .st_vld_o(st_vld_o), .st_cur_o(st_cur_o), .st_prev_o(st_prev_o),
    .rpt_vld_o(rpt_vld_o), .rpt_is_ir_o(rpt_is_ir_o), .rpt_tdi_o(rpt_tdi_o),
    .rpt_tdo_o(rpt_tdo_o), .rpt_len_o(rpt_len_o), .rpt_ovf_o(rpt_ovf_o)
  );

  int n_cmp = 0, n_bad = 0, n_rpt = 0, cyc = 0;
  int last_len = 0;
  bit last_ovf = 0;
  bit done = 0;

  task automatic check(string req, string what, vec_t act, vec_t exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // ---------------- reference model ----------------
  logic [3:0] h [4];
  int   m_cur = 1, m_prev = 1, m_len = 0;
  bit   m_stv = 0, m_rv = 0, m_rir = 0, m_ovf = 0;
  vec_t m_tdi = '0, m_tdo = '0;
  bit   q_di[$], q_do[$];

  function automatic int nxt(int s, bit t);
    case (s)
      0:  return t ? 0 : 1;
      1:  return t ? 2 : 1;
      2:  return t ? 9 : 3;
      3:  return t ? 7 : 6;
      4:  return t ? 2 : 1;
      5:  return t ? 8 : 5;
      6:  return t ? 7 : 6;
      7:  return t ? 4 : 5;
      8:  return t ? 4 : 6;
      9:  return t ? 0 : 10;
      10: return t ? 14 : 13;
      11: return t ? 2 : 1;
      12: return t ? 15 : 12;
      13: return t ? 14 : 13;
      14: return t ? 11 : 12;
      default: return t ? 11 : 13;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = 4'b0;
      m_cur = 1; m_prev = 1; m_stv = 0; m_rv = 0;
      q_di.delete(); q_do.delete();
    end else begin
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0];
      h[0] = {tck, tms, tdi, tdo};
      m_stv = 0; m_rv = 0;
      if (h[2][3] && !h[3][3]) begin
        m_stv  = 1;
        m_prev = m_cur;
        m_cur  = nxt(m_cur, h[2][2]);
        if (m_cur == 6 || m_cur == 13) begin
          q_di.push_back(h[2][1]);
          q_do.push_back(h[2][0]);
        end
        if ((m_prev == 6 && m_cur == 7) || (m_prev == 13 && m_cur == 14)) begin
          m_rv  = 1;
          m_rir = (m_cur == 14);
          m_len = q_di.size();
          m_ovf = (m_len > MAXB);
          m_tdi = '0; m_tdo = '0;
          for (int i = 0; i < q_di.size() && i < MAXB; i++) begin
            m_tdi[i] = q_di[i];
            m_tdo[i] = q_do[i];
          end
          q_di.delete(); q_do.delete();
        end
      end
    end
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (R1..R11 run): actual %0d cycles expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 R5", "st_vld", vec_t'(st_vld_o), vec_t'(m_stv));
      check("R3", "st_cur", vec_t'(st_cur_o), vec_t'(m_cur));
      check("R4", "st_prev", vec_t'(st_prev_o), vec_t'(m_prev));
      check("R7", "rpt_vld", vec_t'(rpt_vld_o), vec_t'(m_rv));
      if (m_rv) begin
        check("R9", "rpt_is_ir", vec_t'(rpt_is_ir_o), vec_t'(m_rir));
        check("R8", "rpt_tdi", rpt_tdi_o, m_tdi);
        check("R6", "rpt_tdo", rpt_tdo_o, m_tdo);
        check("R8", "rpt_len", vec_t'(rpt_len_o), vec_t'(m_len));
        check("R10", "rpt_ovf", vec_t'(rpt_ovf_o), vec_t'(m_ovf));
      end
      if (rpt_vld_o) begin
        n_rpt++;
        last_len = int'(rpt_len_o);
        last_ovf = rpt_ovf_o;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tclk(bit t_ms, bit t_di, bit t_do);
    @(negedge clk);
    tck = 1'b0; tms = t_ms; tdi = t_di; tdo = t_do;
    repeat (3) @(negedge clk);
    tck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic shift_bits(int n);
    for (int i = 0; i < n; i++) tclk(1'b0, 1'($urandom), 1'($urandom));
  endtask

  // From run/idle: full scan of n bits, back to run/idle
  task automatic scan(bit ir, int n);
    tclk(1, 0, 0);
    if (ir) tclk(1, 0, 0);
    tclk(0, 0, 0);
    shift_bits(n);
    tclk(1, 1, 1);
    tclk(1, 0, 0);
    tclk(0, 0, 0);
  endtask

  initial begin
    int r0;
    rst_n = 1'b0; tck = 0; tms = 0; tdi = 0; tdo = 0;
    repeat (4) @(negedge clk);
    #1;
    check("R2", "reset st_cur", vec_t'(st_cur_o), vec_t'(1));
    check("R2", "reset st_prev", vec_t'(st_prev_o), vec_t'(1));
    check("R2", "reset pulses", vec_t'({st_vld_o, rpt_vld_o}), vec_t'(0));
    rst_n = 1'b1;
    settle();
    check("R2", "idle after release", vec_t'(st_cur_o), vec_t'(1));

    // R1: pin activity without a rising test-clock edge
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tms = ~tms; tdi = ~tdi; tdo = ~tdo;
    end
    @(negedge clk); tms = 1; tck = 1;
    settle();
    check("R1", "state after rise with tms=1", vec_t'(st_cur_o), vec_t'(2));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tms = ~tms; tdi = ~tdi;
    end
    @(negedge clk); tck = 0;
    settle();
    check("R1", "state unchanged by fall and noise", vec_t'(st_cur_o), vec_t'(2));

    // R3: reach the reset state and come back to idle
    repeat (5) tclk(1, 0, 0);
    settle();
    check("R3", "reset state code", vec_t'(st_cur_o), vec_t'(0));
    tclk(0, 0, 0);

    // R5: latency probe, from idle with tms=0
    @(negedge clk); tck = 0; tms = 0;
    repeat (4) @(negedge clk);
    tck = 1;
    @(negedge clk); @(negedge clk); #1;
    check("R5", "st_vld one cycle early", vec_t'(st_vld_o), vec_t'(0));
    @(negedge clk); #1;
    check("R5", "st_vld when due", vec_t'(st_vld_o), vec_t'(1));
    repeat (2) @(negedge clk);

    scan(0, 8);
    scan(1, 5);

    // R7: capture straight to exit1 gives no report
    r0 = n_rpt;
    tclk(1, 0, 0); tclk(0, 0, 0); tclk(1, 0, 0); tclk(1, 0, 0); tclk(0, 0, 0);
    settle();
    check("R7", "no report without shift", vec_t'(n_rpt), vec_t'(r0));

    // R11: shift, pause, resume -> two separate reports
    r0 = n_rpt;
    tclk(1, 0, 0); tclk(0, 0, 0);
    shift_bits(5);
    tclk(1, 0, 0); tclk(0, 0, 0); tclk(1, 0, 0);
    shift_bits(3);
    tclk(1, 0, 0); tclk(1, 0, 0); tclk(0, 0, 0);
    settle();
    check("R11", "reports for paused scan", vec_t'(n_rpt - r0), vec_t'(2));
    check("R11", "resumed segment length", vec_t'(last_len), vec_t'(3));

    // R10: overflow and exact fill
    scan(0, 70);
    settle();
    check("R10", "overflow flag", vec_t'(last_ovf), vec_t'(1));
    check("R10", "overflow length", vec_t'(last_len), vec_t'(70));
    scan(1, MAXB);
    settle();
    check("R10", "exact fill flag", vec_t'(last_ovf), vec_t'(0));
    check("R10", "exact fill length", vec_t'(last_len), vec_t'(MAXB));

    // R8: single-bit scan
    scan(0, 1);
    settle();
    check("R8", "one-bit length", vec_t'(last_len), vec_t'(1));

    // R3 R6: free-running mode select walk
    for (int i = 0; i < 60; i++) tclk(1'($urandom), 1'($urandom), 1'($urandom));
    settle();

    done = 1;
    summary();
    $finish;
  end
endmodule